// File: doc/BRIEF.md
# Coefficient Memory Processor Access Port

This block gives a host processor indirect access to a 256-entry coefficient store. Each entry holds an in-phase lane and a quadrature lane, and each lane is 24 bits: a 20-bit mantissa and a 4-bit shift. The host sees three registers on a small write bus. A control register carries a hold bit, which gives the store to the host, and a layout bit. A data register takes successive 16-bit words. An indirect address register both names the entry and the lane and fires the access.

Data words pass through a three-deep shift chain. A write to the address register with the direction bit clear commits the chain contents to the named entry. With the direction bit set, the named lane of the entry is placed on the read bus. Two layouts exist. In the 16-bit layout, two words are staged per entry: the quadrature word first, then the in-phase word. In the floating layout, three words are staged: a word of packed low nibbles, then the upper quadrature mantissa, then the upper in-phase mantissa.

After each accepted access the port stays busy for a fixed number of cycles. Accesses that arrive at a bad time are dropped and recorded in a sticky error flag. While hold is clear, a filter channel reads whole entries through a separate read port.

Top module: `coef_port`

## Requirements
- R1: After reset, `busy`, `err`, `hold` and `rd_valid` are 0.
- R2: Writes to the data register (offset 0x14) or the address register (offset 0x15) while `hold` is 0 are dropped. They change no stored entry, start no busy period and set `err`. Bit 12 of the control register (offset 0x0c) sets `hold`, and bit 0 of that register selects the floating layout.
- R3: In the 16-bit layout, an address write with bit 15 = 0 and a nonzero lane field (bits 9:8) stores the following at entry bits 7:0. The in-phase lane is {last data word, 8'h00} and the quadrature lane is {previous data word, 8'h00}. The channel reads the entry as {in-phase lane, quadrature lane}.
- R4: In the floating layout, with staged words P, Q, I in write order, a write strobe stores in-phase = {I, P[15:8]} and quadrature = {Q, P[7:0]}.
- R5: An address write with bit 15 = 1 drives `rd_data` one cycle later, and `rd_valid` pulses for that one cycle. Lane 01 returns in-phase mantissa bits 19:4, lane 10 returns quadrature mantissa bits 19:4, and lane 11 returns {I mant[3:0], I shift, Q mant[3:0], Q shift}.
- R6: `busy` is high for exactly 4 cycles after each accepted read or write strobe.
- R7: Any write to offset 0x0c, 0x14 or 0x15 while `busy` is high is dropped and sets `err`.
- R8: An address write with lane field 00 is dropped. It starts no busy period, raises no `rd_valid` and sets `err`.
- R9: While `hold` is 0, `ch_data` shows the entry at `ch_addr` one cycle later. While `hold` is 1, `ch_data` keeps its last value.
- R10: `err` stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register offset |
| reg_wdata | input | 16 | Register write data |
| rd_data | output | 16 | Read bus, held until the next read |
| rd_valid | output | 1 | One-cycle pulse when `rd_data` is fresh |
| busy | output | 1 | Access window closed |
| hold | output | 1 | Host owns the store |
| err | output | 1 | Sticky dropped-access flag |
| ch_addr | input | 8 | Channel read index |
| ch_data | output | 48 | Channel entry, {in-phase lane, quadrature lane} |

## Verification
The properties assume that `reg_we` is a single-cycle pulse sampled at each rising edge, and that reset is applied before any access. The busy-length and read-pulse properties also rely on the port itself rejecting anything sent during the busy window. The stimulus therefore drives every write as a one-cycle pulse set up at the falling edge. Outside the tests that aim at the busy window on purpose, it waits out that window before the next access. The host keeps `ch_addr` fixed while checking channel reads, so each channel sample pairs with a single index.

// File: rtl/coef_pkg.sv
package coef_pkg;
    localparam int WORD_W  = 16;
    localparam int MANT_W  = 20;
    localparam int SHIFT_W = 4;

    localparam logic [7:0] OFF_CTRL = 8'h0c;
    localparam logic [7:0] OFF_DATA = 8'h14;
    localparam logic [7:0] OFF_ADDR = 8'h15;

    localparam int BIT_HOLD  = 12;
    localparam int BIT_FLOAT = 0;
    localparam int BIT_DIR   = 15;

    typedef enum logic [1:0] {
        LANE_NONE = 2'b00,
        LANE_I    = 2'b01,
        LANE_Q    = 2'b10,
        LANE_PACK = 2'b11
    } lane_e;

    typedef struct packed {
        logic [MANT_W-1:0]  mant;
        logic [SHIFT_W-1:0] shift;
    } lane_t;

    typedef struct packed {
        lane_t i;
        lane_t q;
    } entry_t;
endpackage

// File: rtl/coef_stage.sv
module coef_stage
    import coef_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] newest,
    output logic [WORD_W-1:0] middle,
    output logic [WORD_W-1:0] oldest
);
    typedef struct packed {
        logic [WORD_W-1:0] w0;
        logic [WORD_W-1:0] w1;
        logic [WORD_W-1:0] w2;
    } stage_t;

    stage_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.w2 = st_q.w1;
            st_d.w1 = st_q.w0;
            st_d.w0 = din;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign newest = st_q.w0;
    assign middle = st_q.w1;
    assign oldest = st_q.w2;
endmodule

// File: rtl/coef_busy.sv
module coef_busy #(
    parameter  int CYCLES = 4,
    localparam int CW     = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    typedef struct packed {
        logic [CW-1:0] cnt;
    } busy_t;

    busy_t b_d, b_q;

    always_comb begin
        b_d = b_q;
        if (start)              b_d.cnt = CW'(CYCLES);
        else if (b_q.cnt != '0) b_d.cnt = b_q.cnt - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

    assign busy = (b_q.cnt != '0);
endmodule

// File: rtl/coef_mem.sv
module coef_mem
    import coef_pkg::*;
#(
    parameter  int DEPTH = 256,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  entry_t        wdata,
    input  logic [AW-1:0] raddr_host,
    output entry_t        rdata_host,
    input  logic [AW-1:0] raddr_chan,
    output entry_t        rdata_chan
);
    entry_t store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
    end

    assign rdata_host = store[raddr_host];
    assign rdata_chan = store[raddr_chan];
endmodule

// File: rtl/coef_port.sv
module coef_port
    import coef_pkg::*;
#(
    parameter  int DEPTH       = 256,
    parameter  int BUSY_CYCLES = 4,
    localparam int AW          = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [7:0]    reg_addr,
    input  logic [15:0]   reg_wdata,
    output logic [15:0]   rd_data,
    output logic          rd_valid,
    output logic          busy,
    output logic          hold,
    output logic          err,
    input  logic [AW-1:0] ch_addr,
    output logic [47:0]   ch_data
);
    typedef struct packed {
        logic               hold;
        logic               flt;
        logic               err;
        logic [WORD_W-1:0]  rd_data;
        logic               rd_valid;
        entry_t             ch;
    } port_t;

    port_t s_d, s_q;

    logic              push;
    logic              mem_we;
    logic              strobe;
    logic [WORD_W-1:0] w_new, w_mid, w_old;
    entry_t            wr_entry;
    entry_t            host_entry;
    entry_t            chan_entry;
    logic              busy_w;

    logic              is_ctrl, is_data, is_addr, known;
    logic              open_win;
    lane_e             lane;
    logic              dir_rd;
    logic [AW-1:0]     ent_idx;
    logic              unused_bits;

    assign unused_bits = ^{reg_wdata[14:13], reg_wdata[11:10]};

    assign is_ctrl  = (reg_addr == OFF_CTRL);
    assign is_data  = (reg_addr == OFF_DATA);
    assign is_addr  = (reg_addr == OFF_ADDR);
    assign known    = is_ctrl | is_data | is_addr;
    assign open_win = reg_we & ~busy_w;
    assign lane     = lane_e'(reg_wdata[9:8]);
    assign dir_rd   = reg_wdata[BIT_DIR];
    assign ent_idx  = reg_wdata[AW-1:0];

    coef_stage u_stage (
        .clk    (clk),
        .rst_n  (rst_n),
        .push   (push),
        .din    (reg_wdata),
        .newest (w_new),
        .middle (w_mid),
        .oldest (w_old)
    );

    coef_busy #(.CYCLES(BUSY_CYCLES)) u_busy (
        .clk   (clk),
        .rst_n (rst_n),
        .start (strobe),
        .busy  (busy_w)
    );

    coef_mem #(.DEPTH(DEPTH)) u_mem (
        .clk        (clk),
        .we         (mem_we),
        .waddr      (ent_idx),
        .wdata      (wr_entry),
        .raddr_host (ent_idx),
        .rdata_host (host_entry),
        .raddr_chan (ch_addr),
        .rdata_chan (chan_entry)
    );

    always_comb begin
        s_d      = s_q;
        push     = 1'b0;
        mem_we   = 1'b0;
        strobe   = 1'b0;
        s_d.rd_valid = 1'b0;

        // Pack the staged words into one entry for the selected layout.
        if (s_q.flt) begin
            wr_entry.i = {w_new, w_old[15:8]};
            wr_entry.q = {w_mid, w_old[7:0]};
        end else begin
            wr_entry.i = {w_new, 8'h00};
            wr_entry.q = {w_mid, 8'h00};
        end

        // Requests during the busy window are dropped and recorded.
        if (reg_we && busy_w && known) s_d.err = 1'b1;

        if (open_win && is_ctrl) begin
            s_d.hold = reg_wdata[BIT_HOLD];
            s_d.flt  = reg_wdata[BIT_FLOAT];
        end

        if (open_win && (is_data || is_addr) && !s_q.hold) s_d.err = 1'b1;

        if (open_win && is_data && s_q.hold) push = 1'b1;

        if (open_win && is_addr && s_q.hold) begin
            if (lane == LANE_NONE) begin
                s_d.err = 1'b1;
            end else begin
                strobe = 1'b1;
                if (dir_rd) begin
                    s_d.rd_valid = 1'b1;
                    unique case (lane)
                        LANE_I:  s_d.rd_data = host_entry.i.mant[MANT_W-1:4];
                        LANE_Q:  s_d.rd_data = host_entry.q.mant[MANT_W-1:4];
                        default: s_d.rd_data = {host_entry.i.mant[3:0], host_entry.i.shift,
                                                host_entry.q.mant[3:0], host_entry.q.shift};
                    endcase
                end else begin
                    mem_we = 1'b1;
                end
            end
        end

        // The channel reads only while the host does not own the store.
        if (!s_q.hold) s_d.ch = chan_entry;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rd_data  = s_q.rd_data;
    assign rd_valid = s_q.rd_valid;
    assign busy     = busy_w;
    assign hold     = s_q.hold;
    assign err      = s_q.err;
    assign ch_data  = s_q.ch;
endmodule

// File: rtl/coef_port_chk.sv
module coef_port_chk
    import coef_pkg::*;
#(
    parameter int BUSY_CYCLES = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_we,
    input logic [7:0]  reg_addr,
    input logic        rd_valid,
    input logic        busy,
    input logic        hold,
    input logic        err,
    input logic [47:0] ch_data
);
    localparam int RW = $clog2(BUSY_CYCLES + 2);
    logic [RW-1:0] run_q;
    logic          known;

    assign known = (reg_addr == OFF_CTRL) || (reg_addr == OFF_DATA) || (reg_addr == OFF_ADDR);

    always_ff @(posedge clk) begin
        if (!rst_n)    run_q <= '0;
        else if (busy) run_q <= (run_q == RW'(BUSY_CYCLES + 1)) ? run_q : run_q + 1'b1;
        else           run_q <= '0;
    end

    a_r6_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_q < RW'(BUSY_CYCLES)));

    a_r6_busy_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> busy);

    a_r5_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    a_r7_busy_drop_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_we && known) |=> err);

    a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    a_r2_read_needs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(hold));

    a_r9_ch_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        $past(hold) |-> $stable(ch_data));
endmodule

bind coef_port coef_port_chk #(.BUSY_CYCLES(BUSY_CYCLES)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .rd_valid (rd_valid),
    .busy     (busy),
    .hold     (hold),
    .err      (err),
    .ch_data  (ch_data)
);

// File: tb/test_coef_port.sv
module test_coef_port;
    localparam int CLK_PERIOD = 10;
    localparam int WATCH      = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] rd_data;
    logic        rd_valid, busy, hold, err;
    logic [7:0]  ch_addr = '0;
    logic [47:0] ch_data;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    coef_port i_coef_port (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .rd_data(rd_data), .rd_valid(rd_valid),
        .busy(busy), .hold(hold), .err(err), .ch_addr(ch_addr), .ch_data(ch_data)
    );

    function automatic logic [15:0] q16(input logic [7:0] a); return (16'(a) * 16'd257) ^ 16'h5a3c; endfunction
    function automatic logic [15:0] i16(input logic [7:0] a); return (16'(a) * 16'd97) + 16'h1111; endfunction
    function automatic logic [15:0] fpk(input logic [7:0] a); return {a[3:0], a[7:4], ~a[3:0], a[7:4] ^ 4'h6}; endfunction
    function automatic logic [15:0] fq(input logic [7:0] a);  return (16'(a) * 16'd331) ^ 16'hc0de; endfunction
    function automatic logic [15:0] fi(input logic [7:0] a);  return (16'(a) * 16'd173) + 16'h0f0f; endfunction

    function automatic logic [47:0] e16(input logic [7:0] a);
        return {i16(a), 8'h00, q16(a), 8'h00};
    endfunction
    function automatic logic [47:0] ef(input logic [7:0] a);
        logic [15:0] p;
        p = fpk(a);
        return {fi(a), p[15:8], fq(a), p[7:0]};
    endfunction

    task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] off, input logic [15:0] val);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = off; reg_wdata = val;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
    endtask

    function automatic logic [15:0] aw(input logic rd, input logic [1:0] ln, input logic [7:0] a);
        return {rd, 5'b0, ln, a};
    endfunction

    initial begin
        idle(3);
        // R1 reset state
        chk("R1 busy", 48'(busy), 48'd0);
        chk("R1 err", 48'(err), 48'd0);
        chk("R1 hold", 48'(hold), 48'd0);
        chk("R1 rd_valid", 48'(rd_valid), 48'd0);
        rst_n = 1'b1;
        idle(1);

        // R3 16-bit layout sweep with host readback (R5)
        wr(8'h0c, 16'h1000);
        chk("R2 hold set", 48'(hold), 48'd1);
        for (int a = 0; a < 256; a++) begin
            wr(8'h14, q16(8'(a)));
            wr(8'h14, i16(8'(a)));
            wr(8'h15, aw(1'b0, 2'b01, 8'(a)));
            idle(4);
        end
        for (int a = 0; a < 256; a++) begin
            wr(8'h15, aw(1'b1, 2'b01, 8'(a)));
            chk("R5 rd_valid", 48'(rd_valid), 48'd1);
            chk("R3 R5 I word", 48'(rd_data), 48'(i16(8'(a))));
            idle(4);
            wr(8'h15, aw(1'b1, 2'b10, 8'(a)));
            chk("R3 R5 Q word", 48'(rd_data), 48'(q16(8'(a))));
            idle(4);
        end
        wr(8'h0c, 16'h0000);
        for (int a = 0; a < 256; a++) begin
            ch_addr = 8'(a);
            @(negedge clk);
            chk("R3 R9 channel entry", ch_data, e16(8'(a)));
        end
        chk("R7 no error so far", 48'(err), 48'd0);

        // R2 host writes without hold are dropped
        wr(8'h14, 16'hdead);
        wr(8'h15, aw(1'b0, 2'b01, 8'd5));
        chk("R2 no busy", 48'(busy), 48'd0);
        chk("R2 err", 48'(err), 48'd1);
        ch_addr = 8'd5;
        idle(2);
        chk("R2 entry kept", ch_data, e16(8'd5));

        // R10 sticky until reset
        wr(8'h0c, 16'h0001);
        idle(3);
        chk("R10 err held", 48'(err), 48'd1);
        do_reset();
        chk("R10 err cleared", 48'(err), 48'd0);

        // R4 floating layout sweep
        wr(8'h0c, 16'h1001);
        for (int a = 0; a < 256; a++) begin
            wr(8'h14, fpk(8'(a)));
            wr(8'h14, fq(8'(a)));
            wr(8'h14, fi(8'(a)));
            wr(8'h15, aw(1'b0, 2'b01, 8'(a)));
            idle(4);
        end
        for (int a = 0; a < 256; a += 3) begin
            wr(8'h15, aw(1'b1, 2'b01, 8'(a)));
            chk("R4 R5 I mant", 48'(rd_data), 48'(fi(8'(a))));
            idle(4);
            wr(8'h15, aw(1'b1, 2'b10, 8'(a)));
            chk("R4 R5 Q mant", 48'(rd_data), 48'(fq(8'(a))));
            idle(4);
            wr(8'h15, aw(1'b1, 2'b11, 8'(a)));
            chk("R4 R5 packed", 48'(rd_data), 48'(fpk(8'(a))));
            idle(4);
        end
        chk("R7 no error in float sweep", 48'(err), 48'd0);

        // R6 busy window length
        wr(8'h15, aw(1'b1, 2'b01, 8'h10));
        chk("R6 busy 1", 48'(busy), 48'd1);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R6 busy held", 48'(busy), 48'd1);
        end
        @(negedge clk);
        chk("R6 busy ends", 48'(busy), 48'd0);

        // R7 writes during busy are dropped
        wr(8'h15, aw(1'b1, 2'b10, 8'h10));
        chk("R7 read before drop", 48'(rd_data), 48'(fq(8'h10)));
        wr(8'h14, 16'h1234);
        wr(8'h15, aw(1'b0, 2'b01, 8'h20));
        chk("R7 err", 48'(err), 48'd1);
        idle(4);
        wr(8'h15, aw(1'b1, 2'b01, 8'h20));
        chk("R7 entry kept I", 48'(rd_data), 48'(fi(8'h20)));
        idle(4);
        wr(8'h15, aw(1'b1, 2'b11, 8'h20));
        chk("R7 entry kept packed", 48'(rd_data), 48'(fpk(8'h20)));
        idle(4);

        // R9 channel output frozen while hold is set
        do_reset();
        ch_addr = 8'd7;
        idle(2);
        chk("R9 channel live", ch_data, ef(8'd7));
        wr(8'h0c, 16'h1001);
        ch_addr = 8'd9;
        idle(3);
        chk("R9 channel frozen", ch_data, ef(8'd7));

        // R8 lane field 00 is dropped
        wr(8'h15, aw(1'b1, 2'b00, 8'h10));
        chk("R8 no rd_valid", 48'(rd_valid), 48'd0);
        chk("R8 no busy", 48'(busy), 48'd0);
        chk("R8 err", 48'(err), 48'd1);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        for (int k = 0; k < WATCH; k++) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule